// File: doc/BRIEF.md
# Card-side parameter-selection request handler

This block sits on the card side of a contact smart-card link and runs once the answer-to-reset has gone out. During the negotiation window it takes bytes from the receiver one at a time. If the first byte is the request lead value, the block collects a parameter-selection request. The format byte decides how long the request is, and the block checks both the structure and a running XOR over every byte. An accepted request is sent back to the terminal unchanged, byte for byte, and the negotiated protocol type and rate byte are then reported. A rejected request makes the block go quiet until the card is reset again. Bit-level framing and the actual change of the baud divisor belong to other blocks.

A first byte that is not the lead value closes the window at once. That byte is passed on as the start of an ordinary command, and so is everything after it. All three byte interfaces use valid/ready. A byte moves only in a cycle where both valid and ready are high. The producer must hold valid and data steady until that cycle. The block holds `tx_data` steady while `tx_valid` waits on `tx_ready`. Inbound bytes are held off (`rx_ready` low) while an echo is in progress. Bytes passed on as commands see the back-pressure of `cmd_ready` directly.

Top module: `psel_negotiator`

## Requirements
- R1: After the check byte of an accepted request has been taken, the block transmits every request byte on `tx_*` in the order received, values unchanged, and nothing else.
- R2: The request is lead byte 0xFF, format byte, one optional byte for each set bit among format bits 4, 5 and 6 (in that order: rate byte, second parameter, reserved parameter), then one check byte. Total length is 3 plus the number of those set bits.
- R3: If the XOR of all request bytes, check byte included, is not zero, nothing is transmitted. From then on every inbound byte is consumed and dropped, and no command byte is produced.
- R4: A format byte with bit 7 set, or whose low nibble names a protocol whose bit in `supp_mask` is clear, causes the same silent rejection as R3.
- R5: A reserved parameter byte that is present and not 0x00 causes the same silent rejection as R3.
- R6: `neg_valid` stays low until the cycle after the last echoed byte is handed over. It then rises, with `neg_proto` equal to the format byte's low nibble and `neg_rate` equal to the rate byte, or to 0x11 when the rate byte is absent.
- R7: If the first byte of a window is not 0xFF, it and every later byte appear unchanged on `cmd_*`, including later 0xFF bytes. No echo is ever sent in this case.
- R8: After a successful exchange, a first following byte of 0xFF is a repeated request. It is dropped and the block goes silent as in R3. Any other first byte starts command forwarding.
- R9: While the echo is in progress `rx_ready` is low, and `tx_data` stays stable while `tx_valid` is high and `tx_ready` low.
- R10: A one-cycle `card_rst` reopens the negotiation window and clears `neg_valid`.
- R11: Out of reset `tx_valid`, `cmd_valid` and `neg_valid` are low, and a 0xFF byte is accepted (`rx_ready` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| card_rst | input | 1 | Card reset seen; reopens the window |
| supp_mask | input | 16 | Bit n set: protocol type n supported |
| rx_valid | input | 1 | Inbound byte valid |
| rx_ready | output | 1 | Inbound byte accepted |
| rx_data | input | 8 | Inbound byte |
| tx_valid | output | 1 | Echo byte valid |
| tx_ready | input | 1 | Transmitter accepts echo byte |
| tx_data | output | 8 | Echo byte |
| cmd_valid | output | 1 | Forwarded command byte valid |
| cmd_ready | input | 1 | Command consumer accepts byte |
| cmd_data | output | 8 | Forwarded command byte |
| neg_valid | output | 1 | Negotiated values valid |
| neg_proto | output | 4 | Negotiated protocol type |
| neg_rate | output | 8 | Negotiated rate byte |

## Verification
The assertions rely on a few things from the inputs. The rx producer must hold `rx_valid` and `rx_data` until `rx_ready`. `card_rst` must be a single synchronous pulse. `supp_mask` must stay constant during a request. The bench drives bytes through one task that holds them until the handshake cycle, and it fixes the mask for the whole run. It pulses the card reset for one cycle only, between requests. The bench also varies `tx_ready` and `cmd_ready` from a pseudo-random pattern on alternate cases. This exercises the echo-hold and forwarding back-pressure rules without breaking any of those assumptions.

// File: rtl/psel_pkg.sv
package psel_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned REQ_MAX  = 6;
  localparam int unsigned IDX_W    = $clog2(REQ_MAX + 1);
  localparam logic [BYTE_W-1:0] LEAD_BYTE = 8'hFF;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    M_OPEN,
    M_COLLECT,
    M_ECHO,
    M_POST,
    M_CMD,
    M_MUTE
  } mode_e;
endpackage

// File: rtl/psel_req_parser.sv
module psel_req_parser
  import psel_pkg::*;
#(
  parameter int unsigned PROTO_W      = 4,
  parameter logic [7:0]  DEFAULT_RATE = 8'h11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       take,
  input  byte_t                      din,
  input  logic [(1<<PROTO_W)-1:0]    supp_mask,
  output logic                       last_take,
  output logic                       req_ok,
  output logic [IDX_W-1:0]           req_len,
  output logic [PROTO_W-1:0]         req_proto,
  output byte_t                      req_rate,
  output byte_t [REQ_MAX-1:0]        req_buf
);

  logic [IDX_W-1:0] idx, exp_len, slot, len_from_fmt;
  logic [2:0]       pres_q;
  byte_t            xor_acc;
  logic             err;
  logic [1:0]       kind;
  logic             fmt_bad, p3_bad, is_fmt, is_param;

  function automatic logic [1:0] slot_kind(input logic [2:0] pres,
                                           input logic [IDX_W-1:0] s);
    logic [IDX_W-1:0] seen;
    slot_kind = 2'd0;
    seen = '0;
    for (int b = 0; b < 3; b++) begin
      if (pres[b]) begin
        if (seen == s && slot_kind == 2'd0) slot_kind = 2'(b + 1);
        seen = IDX_W'(seen + 1);
      end
    end
  endfunction

  always_comb begin
    is_fmt       = (idx == IDX_W'(1));
    slot         = IDX_W'(idx - IDX_W'(2));
    kind         = slot_kind(pres_q, slot);
    len_from_fmt = IDX_W'(32'd3 + 32'(din[4]) + 32'(din[5]) + 32'(din[6]));
    fmt_bad      = din[7] || !supp_mask[din[PROTO_W-1:0]];
    last_take    = take && (idx >= IDX_W'(2)) && (idx == IDX_W'(exp_len - IDX_W'(1)));
    is_param     = take && (idx >= IDX_W'(2)) && !last_take;
    p3_bad       = (kind == 2'd3) && (din != 8'h00);
    req_ok       = !err && ((xor_acc ^ din) == 8'h00);
    req_len      = exp_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx       <= '0;
      exp_len   <= '0;
      pres_q    <= '0;
      xor_acc   <= '0;
      err       <= 1'b0;
      req_proto <= '0;
      req_rate  <= DEFAULT_RATE;
      req_buf   <= '0;
    end else if (clr) begin
      idx       <= '0;
      exp_len   <= '0;
      pres_q    <= '0;
      xor_acc   <= '0;
      err       <= 1'b0;
      req_proto <= '0;
      req_rate  <= DEFAULT_RATE;
    end else if (take) begin
      for (int i = 0; i < REQ_MAX; i++) begin
        if (idx == IDX_W'(i)) req_buf[i] <= din;
      end
      xor_acc <= xor_acc ^ din;
      idx     <= IDX_W'(idx + IDX_W'(1));
      if (is_fmt) begin
        pres_q    <= din[6:4];
        exp_len   <= len_from_fmt;
        req_proto <= din[PROTO_W-1:0];
        req_rate  <= DEFAULT_RATE;
        err       <= err | fmt_bad;
      end
      if (is_param) begin
        if (kind == 2'd1) req_rate <= din;
        err <= err | p3_bad;
      end
    end
  end

  // R2: no byte is taken past the length the format byte announced
  a_r2_len_bound: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (take && idx >= IDX_W'(2)) |-> (idx < exp_len));

endmodule

// File: rtl/psel_echo_tx.sv
module psel_echo_tx
  import psel_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                start,
  input  logic [IDX_W-1:0]    len,
  input  byte_t [REQ_MAX-1:0] src,
  output logic                tx_valid,
  input  logic                tx_ready,
  output byte_t               tx_data,
  output logic                tx_last,
  output logic                finish
);

  logic             busy;
  logic [IDX_W-1:0] ptr, len_q;

  always_comb begin
    tx_data = '0;
    for (int i = 0; i < REQ_MAX; i++) begin
      if (ptr == IDX_W'(i)) tx_data = src[i];
    end
    tx_valid = busy;
    tx_last  = busy && (ptr == IDX_W'(len_q - IDX_W'(1)));
    finish   = tx_valid && tx_ready && tx_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ptr   <= '0;
      len_q <= '0;
    end else if (clr) begin
      busy  <= 1'b0;
      ptr   <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      ptr   <= '0;
      len_q <= len;
    end else if (tx_valid && tx_ready) begin
      if (tx_last) busy <= 1'b0;
      else         ptr  <= IDX_W'(ptr + IDX_W'(1));
    end
  end

  // R9: a stalled echo byte holds its value
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

endmodule

// File: rtl/psel_negotiator.sv
module psel_negotiator
  import psel_pkg::*;
#(
  parameter int unsigned PROTO_W      = 4,
  parameter logic [7:0]  DEFAULT_RATE = 8'h11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    card_rst,
  input  logic [(1<<PROTO_W)-1:0] supp_mask,
  input  logic                    rx_valid,
  output logic                    rx_ready,
  input  logic [7:0]              rx_data,
  output logic                    tx_valid,
  input  logic                    tx_ready,
  output logic [7:0]              tx_data,
  output logic                    cmd_valid,
  input  logic                    cmd_ready,
  output logic [7:0]              cmd_data,
  output logic                    neg_valid,
  output logic [PROTO_W-1:0]      neg_proto,
  output logic [7:0]              neg_rate
);

  mode_e               mode, mode_nx;
  logic                is_lead, route_cmd, rx_hs, take;
  logic                last_take, req_ok, echo_start, tx_last, finish;
  logic [IDX_W-1:0]    req_len;
  logic [PROTO_W-1:0]  req_proto;
  byte_t               req_rate;
  byte_t [REQ_MAX-1:0] req_buf;

  always_comb begin
    is_lead   = (rx_data == LEAD_BYTE);
    route_cmd = (mode == M_CMD) ||
                ((mode == M_OPEN || mode == M_POST) && !is_lead);
    if (card_rst)           rx_ready = 1'b0;
    else if (route_cmd)     rx_ready = cmd_ready;
    else if (mode == M_ECHO) rx_ready = 1'b0;
    else                    rx_ready = 1'b1;
    cmd_valid  = rx_valid && route_cmd && !card_rst;
    cmd_data   = rx_data;
    rx_hs      = rx_valid && rx_ready;
    take       = rx_hs && ((mode == M_OPEN && is_lead) || mode == M_COLLECT);
    echo_start = last_take && req_ok;
  end

  always_comb begin
    mode_nx = mode;
    unique case (mode)
      M_OPEN:    if (rx_hs) mode_nx = is_lead ? M_COLLECT : M_CMD;
      M_COLLECT: if (last_take) mode_nx = req_ok ? M_ECHO : M_MUTE;
      M_ECHO:    if (finish) mode_nx = M_POST;
      M_POST:    if (rx_hs) mode_nx = is_lead ? M_MUTE : M_CMD;
      M_CMD:     mode_nx = M_CMD;
      M_MUTE:    mode_nx = M_MUTE;
      default:   mode_nx = M_MUTE;
    endcase
    if (card_rst) mode_nx = M_OPEN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode      <= M_OPEN;
      neg_valid <= 1'b0;
      neg_proto <= '0;
      neg_rate  <= DEFAULT_RATE;
    end else begin
      mode <= mode_nx;
      if (card_rst) begin
        neg_valid <= 1'b0;
      end else if (finish) begin
        neg_valid <= 1'b1;
        neg_proto <= req_proto;
        neg_rate  <= req_rate;
      end
    end
  end

  psel_req_parser #(
    .PROTO_W      (PROTO_W),
    .DEFAULT_RATE (DEFAULT_RATE)
  ) u_parser (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (card_rst),
    .take      (take),
    .din       (rx_data),
    .supp_mask (supp_mask),
    .last_take (last_take),
    .req_ok    (req_ok),
    .req_len   (req_len),
    .req_proto (req_proto),
    .req_rate  (req_rate),
    .req_buf   (req_buf)
  );

  psel_echo_tx u_echo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (card_rst),
    .start    (echo_start),
    .len      (req_len),
    .src      (req_buf),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .finish   (finish)
  );

  // R3: the silent state emits neither echo nor command bytes
  a_r3_mute_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_MUTE) |-> (!tx_valid && !cmd_valid));

  // R8: silence lasts until a card reset
  a_r8_mute_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_MUTE && !card_rst) |=> (mode == M_MUTE));

  // R1: echo bytes appear only during the echo phase
  a_r1_tx_in_echo: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (mode == M_ECHO));

  // R6: results become valid right after the final echo handshake
  a_r6_valid_after_echo: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(neg_valid) |-> $past(tx_valid && tx_ready && tx_last));

  // R10: a card reset reopens the window and drops the results
  a_r10_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |=> (mode == M_OPEN && !neg_valid));

endmodule

// File: tb/psel_negotiator_test.sv
module psel_negotiator_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        card_rst = 1'b0;
  logic [15:0] supp_mask = 16'h4003;
  logic        rx_valid = 1'b0;
  logic        rx_ready;
  logic [7:0]  rx_data = 8'hFF;
  logic        tx_valid;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [7:0]  cmd_data;
  logic        neg_valid;
  logic [3:0]  neg_proto;
  logic [7:0]  neg_rate;

  int checks = 0;
  int fails  = 0;
  int tx_cnt = 0;
  int cmd_cnt = 0;
  logic [7:0] tx_log  [0:1023];
  logic [7:0] cmd_log [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  bit bp_mode = 1'b0;

  logic [7:0] req [0:5];
  int req_len;

  always #5 clk = ~clk;

  psel_negotiator uut (
    .clk(clk), .rst_n(rst_n), .card_rst(card_rst), .supp_mask(supp_mask),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .neg_valid(neg_valid), .neg_proto(neg_proto), .neg_rate(neg_rate)
  );

  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready  = bp_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
    cmd_ready = bp_mode ? (lfsr[5] | lfsr[7]) : 1'b1;
  end

  always @(negedge clk) begin
    if (tx_valid && tx_ready) begin
      tx_log[tx_cnt % 1024] = tx_data;
      tx_cnt = tx_cnt + 1;
    end
    if (cmd_valid && cmd_ready) begin
      cmd_log[cmd_cnt % 1024] = cmd_data;
      cmd_cnt = cmd_cnt + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    #1;
    while (!rx_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    rx_valid = 1'b0;
  endtask

  task automatic pulse_card_rst();
    @(negedge clk);
    card_rst = 1'b1;
    @(negedge clk);
    card_rst = 1'b0;
  endtask

  task automatic build(input int pres, input int proto, input logic [7:0] p1,
                       input logic [7:0] p2, input logic [7:0] p3, input bit bad_ck,
                       input bit fmt_hi);
    logic [7:0] ck;
    req_len = 0;
    req[req_len++] = 8'hFF;
    req[req_len++] = {fmt_hi, 3'(pres), 4'(proto)};
    if (pres[0]) req[req_len++] = p1;
    if (pres[1]) req[req_len++] = p2;
    if (pres[2]) req[req_len++] = p3;
    ck = 8'h00;
    for (int i = 0; i < req_len; i++) ck = ck ^ req[i];
    if (bad_ck) ck = ck ^ 8'h01;
    req[req_len++] = ck;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int case_no;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R11 reset state
    chk("R11 tx_valid", tx_valid, 0);
    chk("R11 cmd_valid", cmd_valid, 0);
    chk("R11 neg_valid", neg_valid, 0);
    chk("R11 rx_ready", rx_ready, 1);

    case_no = 0;
    for (int pr = 0; pr < 4; pr++) begin
      for (int pres = 0; pres < 8; pres++) begin
        for (int bad = 0; bad < 3; bad++) begin
          int proto, base_tx, base_cmd, exp_cmd;
          bit acc;
          logic [7:0] p1, p3, fb, exp_rate;
          if (bad == 2 && pres[2] == 1'b0) continue;
          proto = (pr == 0) ? 0 : (pr == 1) ? 1 : (pr == 2) ? 14 : 7;
          p1 = 8'h90 + 8'(pres) + 8'(proto);
          p3 = (bad == 2) ? 8'h5A : 8'h00;
          build(pres, proto, p1, 8'hC0 ^ 8'(proto), p3, bad == 1, 1'b0);
          acc = (bad == 0) && supp_mask[proto];
          exp_rate = pres[0] ? p1 : 8'h11;
          bp_mode = case_no[0];
          base_tx = tx_cnt;
          base_cmd = cmd_cnt;
          for (int i = 0; i < req_len; i++) send_byte(req[i]);
          // R6 not yet valid; R9 inbound held off during echo
          chk("R6 early neg_valid", neg_valid, 0);
          chk("R9 rx_ready in echo", rx_ready, acc ? 0 : 1);
          chk("R1 echo starts", tx_valid, acc ? 1 : 0);
          repeat (60) @(negedge clk);
          // R1 / R2 / R3 / R4 / R5 echo length and content
          chk(acc ? "R1 echo count" : (bad == 1 ? "R3 silent" :
              (bad == 2 ? "R5 silent" : "R4 silent")), tx_cnt - base_tx, acc ? req_len : 0);
          if (acc) begin
            for (int i = 0; i < req_len; i++)
              chk("R2 echo byte", tx_log[(base_tx + i) % 1024], req[i]);
            chk("R6 proto", neg_proto, proto);
            chk("R6 rate", neg_rate, exp_rate);
          end
          chk("R6 neg_valid", neg_valid, acc ? 1 : 0);
          fb = case_no[1] ? 8'hFF : 8'h3C;
          if (!acc) fb = 8'h3C;
          send_byte(fb);
          repeat (4) @(negedge clk);
          exp_cmd = (acc && fb != 8'hFF) ? 1 : 0;
          chk(acc ? "R8 follow byte" : "R3 mute follow", cmd_cnt - base_cmd, exp_cmd);
          if (exp_cmd == 1) chk("R8 cmd data", cmd_log[base_cmd % 1024], fb);
          chk("R8 no second echo", tx_cnt - base_tx, acc ? req_len : 0);
          if (acc && fb == 8'hFF) begin
            send_byte(8'h3C);
            repeat (4) @(negedge clk);
            chk("R8 silent after repeat", cmd_cnt - base_cmd, 0);
          end
          pulse_card_rst();
          #1;
          chk("R10 neg_valid cleared", neg_valid, 0);
          case_no++;
        end
      end
    end

    // R4: reserved format bit set
    begin
      int base_tx;
      bp_mode = 1'b0;
      build(0, 1, 8'h00, 8'h00, 8'h00, 1'b0, 1'b1);
      base_tx = tx_cnt;
      for (int i = 0; i < req_len; i++) send_byte(req[i]);
      repeat (20) @(negedge clk);
      chk("R4 format bit7", tx_cnt - base_tx, 0);
      chk("R4 neg_valid", neg_valid, 0);
      pulse_card_rst();
    end

    // R7: non-lead first byte closes the window
    begin
      int base_tx, base_cmd;
      bp_mode = 1'b1;
      build(1, 0, 8'h13, 8'h00, 8'h00, 1'b0, 1'b0);
      base_tx = tx_cnt;
      base_cmd = cmd_cnt;
      send_byte(8'h55);
      for (int i = 0; i < req_len; i++) send_byte(req[i]);
      repeat (20) @(negedge clk);
      chk("R7 forwarded count", cmd_cnt - base_cmd, 1 + req_len);
      chk("R7 first byte", cmd_log[base_cmd % 1024], 8'h55);
      for (int i = 0; i < req_len; i++)
        chk("R7 forwarded byte", cmd_log[(base_cmd + 1 + i) % 1024], req[i]);
      chk("R7 no echo", tx_cnt - base_tx, 0);
      chk("R7 neg_valid", neg_valid, 0);
      pulse_card_rst();
    end

    // R10: window reopens after reset and accepts again
    begin
      int base_tx;
      bp_mode = 1'b0;
      build(3, 14, 8'h96, 8'h0F, 8'h00, 1'b0, 1'b0);
      base_tx = tx_cnt;
      for (int i = 0; i < req_len; i++) send_byte(req[i]);
      repeat (20) @(negedge clk);
      chk("R10 reopened echo", tx_cnt - base_tx, req_len);
      chk("R10 proto", neg_proto, 14);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule